// File: doc/BRIEF.md
# Select-Gated SPI Slave

This block is the receiving end of a four-wire serial link. An outside master supplies the serial clock and an active-low select line. The block exchanges one byte per frame in both directions at once. The clock polarity, the clock phase and the bit order are configuration inputs. The select line gates everything. While the slave is deselected, its data output is released and clock edges are ignored. Once selected, the slave presents the first outgoing bit without waiting for a clock edge. If the select line is released in the middle of a frame, that frame is discarded.

All pins are brought into the system clock domain through flip-flop synchronizers. Edges are then detected on the synchronized copies. Local logic loads the next outgoing byte through a holding register. It reads received bytes from a receive buffer that has a full flag. A pin-mode input selects one of three data arrangements:

- separate data-in and data-out pins;
- one shared data pin whose direction is set by a configuration bit;
- a receive-only arrangement that never drives a pin.

Top module: `spis_slave`

## Requirements
- R1: After reset, `rxByte` is 0, `rxFull` is 0, and both `misoOe` and `sioOe` are 0.
- R2: While `ssNIn` is high, neither output enable is asserted. Clock transitions on `sckIn` shift nothing and count no bits, so a later frame is still received intact.
- R3: After `ssNIn` falls, the first outgoing bit of the transmit holding register is on the data output before the first sampling edge.
- R4: The leading edge is rising when `cfgCpol`=0 and falling when `cfgCpol`=1. With `cfgCpha`=0, bits are sampled on leading edges and the output advances on trailing edges. With `cfgCpha`=1, the output advances on leading edges and bits are sampled on trailing edges.
- R5: With `cfgLsbFirst`=1, bit 0 is sent and received first. With `cfgLsbFirst`=0, bit 7 goes first. Both directions of a frame use the same order.
- R6: After the eighth sampled bit, the received byte appears on `rxByte` and `rxFull` is set. While `ssNIn` stays low, the next frame follows directly and sends a freshly loaded transmit byte.
- R7: A one-cycle `rxRead` pulse clears `rxFull`. A frame that completes while `rxFull` is still set replaces `rxByte`.
- R8: A rise of `ssNIn` before the eighth sampled bit leaves `rxByte` and `rxFull` unchanged. The next frame starts again from its first bit.
- R9: `cfgPinMode` selects the pins. Code 0 receives on `mosiIn` and drives `misoOut`/`misoOe`. Code 1 receives on `sioIn` and drives `sioOut`/`sioOe` only when `cfgDirOut`=1. Codes 2 and 3 receive on `mosiIn` and drive no pin.
- R10: A `txWrite` during a frame does not alter the bits of that frame. The new byte is sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the master |
| ssNIn | input | 1 | Active-low select from the master |
| mosiIn | input | 1 | Serial data in (separate-pin and receive-only modes) |
| misoOut | output | 1 | Serial data out (separate-pin mode) |
| misoOe | output | 1 | Output enable for `misoOut` |
| sioIn | input | 1 | Shared data pin, input path |
| sioOut | output | 1 | Shared data pin, output path |
| sioOe | output | 1 | Shared data pin output enable |
| cfgCpol | input | 1 | Clock idle level |
| cfgCpha | input | 1 | Clock phase select |
| cfgLsbFirst | input | 1 | 1 = least significant bit first |
| cfgPinMode | input | 2 | 0 separate pins, 1 shared pin, 2/3 receive only |
| cfgDirOut | input | 1 | Shared pin drives out when 1 |
| txWrite | input | 1 | Load `txByte` into the transmit holding register |
| txByte | input | 8 | Next byte to transmit |
| rxRead | input | 1 | Acknowledge the receive buffer, clears `rxFull` |
| rxByte | output | 8 | Last completed received byte |
| rxFull | output | 1 | Set on frame completion |

## Verification
The hardest situations to reach are a select release that lands partway through a frame, and the hand-over between two frames while select stays low. In the second case, the new transmit byte must appear exactly at the right drive edge. A bench-side master model makes both reachable. It releases select after a chosen number of bits. It can also run consecutive frames without deselecting, and it writes a new transmit byte in the middle of the first frame. Random frames over all polarity, phase, order and pin-mode combinations then exercise the remaining edge mappings.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic [1:0] {
    PM_DUPLEX = 2'd0,
    PM_BIDIR  = 2'd1,
    PM_RXONLY = 2'd2,
    PM_RSVD   = 2'd3
  } pinMode_e;

  // Strobes from the control path to the datapath, one cycle each
  typedef struct packed {
    logic load;    // copy holding register into transmit shifter
    logic shift;   // advance transmit shifter by one bit
    logic sample;  // capture one received bit
    logic done;    // this sample completes the frame
    logic abort;   // select released, discard partial frame
  } strobe_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RST_VAL;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= RST_VAL;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/spis_ctrl.sv
module spis_ctrl import spis_pkg::*; #(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             ssNS,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  output strobe_t          stb,
  output logic             selected,
  output logic [CNT_W-1:0] bitCnt
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic sckPrev, ssNPrev, loadNext;
  logic sckRise, sckFall, leadEdge, trailEdge;
  logic ssFall, ssRise, active;
  logic sampleEdge, driveEdge, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      ssNPrev <= 1'b1;
    end else begin
      sckPrev <= sckS;
      ssNPrev <= ssNS;
    end
  end

  always_comb begin
    sckRise    = sckS & ~sckPrev;
    sckFall    = ~sckS & sckPrev;
    leadEdge   = cfgCpol ? sckFall : sckRise;
    trailEdge  = cfgCpol ? sckRise : sckFall;
    ssFall     = ssNPrev & ~ssNS;
    ssRise     = ~ssNPrev & ssNS;
    active     = ~ssNS & ~ssNPrev;
    sampleEdge = active & (cfgCpha ? trailEdge : leadEdge);
    driveEdge  = active & (cfgCpha ? leadEdge : trailEdge);
    lastBit    = (bitCnt == LAST_BIT);
  end

  // After select falls (phase 1) or a frame ends, the next drive edge loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        loadNext <= 1'b0;
    else if (ssRise)                  loadNext <= 1'b0;
    else if (ssFall)                  loadNext <= cfgCpha;
    else if (sampleEdge && lastBit)   loadNext <= 1'b1;
    else if (driveEdge)               loadNext <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (ssNS)          bitCnt <= '0;
    else if (sampleEdge)    bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_comb begin
    stb.load   = ssFall | (driveEdge & loadNext);
    stb.shift  = driveEdge & ~loadNext;
    stb.sample = sampleEdge;
    stb.done   = sampleEdge & lastBit;
    stb.abort  = ssRise;
  end

  assign selected = ~ssNS;

endmodule

// File: rtl/spis_dpath.sv
module spis_dpath import spis_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              selected,
  input  logic              cfgLsbFirst,
  input  pinMode_e          pinMode,
  input  logic              cfgDirOut,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txByte,
  input  logic              mosiS,
  input  logic              sioS,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxFull,
  output logic              misoOut,
  output logic              misoOe,
  output logic              sioOut,
  output logic              sioOe
);

  logic [DATA_W-1:0] txHold, txShift, rxShift, rxNext;
  logic rxIn, txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        txHold <= '0;
    else if (txWrite) txHold <= txByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txShift <= '0;
    else if (stb.load)  txShift <= txHold;
    else if (stb.shift) txShift <= cfgLsbFirst ? {1'b0, txShift[DATA_W-1:1]}
                                               : {txShift[DATA_W-2:0], 1'b0};
  end

  assign txBit = cfgLsbFirst ? txShift[0] : txShift[DATA_W-1];
  assign rxIn  = (pinMode == PM_BIDIR) ? sioS : mosiS;

  always_comb begin
    rxNext = cfgLsbFirst ? {rxIn, rxShift[DATA_W-1:1]}
                         : {rxShift[DATA_W-2:0], rxIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxShift <= '0;
    else if (stb.abort)  rxShift <= '0;
    else if (stb.sample) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxByte <= '0;
    else if (stb.done) rxByte <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxFull <= 1'b0;
    else if (stb.done) rxFull <= 1'b1;
    else if (rxRead)   rxFull <= 1'b0;
  end

  always_comb begin
    misoOe  = selected & (pinMode == PM_DUPLEX);
    sioOe   = selected & (pinMode == PM_BIDIR) & cfgDirOut;
    misoOut = misoOe & txBit;
    sioOut  = sioOe & txBit;
  end

endmodule

// File: rtl/spis_slave.sv
module spis_slave import spis_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              sioIn,
  output logic              sioOut,
  output logic              sioOe,
  input  logic              cfgCpol,
  input  logic              cfgCpha,
  input  logic              cfgLsbFirst,
  input  logic [1:0]        cfgPinMode,
  input  logic              cfgDirOut,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txByte,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxFull
);

  logic sckS, ssNS, mosiS, sioS, selected, frameDone;
  logic [CNT_W-1:0] bitCnt;
  strobe_t stb;

  // bit order {sio, mosi, ssN, sck}; select resets to deasserted
  spis_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sioIn, mosiIn, ssNIn, sckIn}),
    .syncOut({sioS, mosiS, ssNS, sckS})
  );

  spis_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckS), .ssNS(ssNS),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .stb(stb), .selected(selected), .bitCnt(bitCnt)
  );

  spis_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .selected(selected),
    .cfgLsbFirst(cfgLsbFirst), .pinMode(pinMode_e'(cfgPinMode)),
    .cfgDirOut(cfgDirOut), .txWrite(txWrite), .txByte(txByte),
    .mosiS(mosiS), .sioS(sioS), .rxRead(rxRead),
    .rxByte(rxByte), .rxFull(rxFull),
    .misoOut(misoOut), .misoOe(misoOe), .sioOut(sioOut), .sioOe(sioOe)
  );

  assign frameDone = stb.done;

endmodule

// File: rtl/spis_slave_chk.sv
module spis_slave_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ssNIn,
  input logic              misoOe,
  input logic              sioOe,
  input logic [1:0]        cfgPinMode,
  input logic              rxRead,
  input logic              rxFull,
  input logic [DATA_W-1:0] rxByte,
  input logic              frameDone,
  input logic [CNT_W-1:0]  bitCnt
);

  p_release_desel_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ssNIn && $past(ssNIn, 1) && $past(ssNIn, 2) && $past(ssNIn, 3))
      |-> (!misoOe && !sioOe));

  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ssNIn && $past(ssNIn, 1) && $past(ssNIn, 2) && $past(ssNIn, 3))
      |-> (bitCnt == '0));

  p_full_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> rxFull);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !frameDone) |=> !rxFull);

  p_buf_only_on_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxByte) |-> $past(frameDone));

  p_one_driver_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({misoOe, sioOe}));

  p_rxonly_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgPinMode[1] |-> (!misoOe && !sioOe));

endmodule

bind spis_slave spis_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ssNIn(ssNIn), .misoOe(misoOe), .sioOe(sioOe),
  .cfgPinMode(cfgPinMode), .rxRead(rxRead), .rxFull(rxFull), .rxByte(rxByte),
  .frameDone(frameDone), .bitCnt(bitCnt)
);

// File: tb/spis_slave_test.sv
module spis_slave_test;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, ssNIn = 1'b1, mosiIn = 1'b0, sioIn = 1'b0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0, cfgDirOut = 1'b0;
  logic [1:0] cfgPinMode = 2'd0;
  logic txWrite = 1'b0, rxRead = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic misoOut, misoOe, sioOut, sioOe, rxFull;
  logic [7:0] rxByte;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  spis_slave uut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .ssNIn(ssNIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .sioIn(sioIn), .sioOut(sioOut),
    .sioOe(sioOe), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLsbFirst(cfgLsbFirst), .cfgPinMode(cfgPinMode), .cfgDirOut(cfgDirOut),
    .txWrite(txWrite), .txByte(txByte), .rxRead(rxRead),
    .rxByte(rxByte), .rxFull(rxFull)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit bitOf(input logic [7:0] b, input bit lsb, input int i);
    return lsb ? b[i] : b[7-i];
  endfunction

  task automatic setCfg(input bit pol, input bit pha, input bit lsb,
                        input logic [1:0] pm, input bit dOut);
    cfgCpol = pol; cfgCpha = pha; cfgLsbFirst = lsb;
    cfgPinMode = pm; cfgDirOut = dOut;
    sckIn = pol;
    cyc(6);
  endtask

  task automatic writeTx(input logic [7:0] b);
    txByte = b; txWrite = 1'b1;
    cyc(1);
    txWrite = 1'b0;
  endtask

  task automatic readRx();
    rxRead = 1'b1;
    cyc(1);
    rxRead = 1'b0;
    cyc(1);
  endtask

  // In shared-pin mode the other input carries the opposite value
  task automatic setDin(input bit v);
    if (cfgPinMode == 2'd1) begin sioIn = v; mosiIn = ~v; end
    else begin mosiIn = v; sioIn = ~v; end
  endtask

  task automatic checkOut(input bit expBit, input string req);
    bit em, es, got;
    em = (cfgPinMode == 2'd0);
    es = (cfgPinMode == 2'd1) && cfgDirOut;
    chk({misoOe, sioOe} == {em, es}, "R9", "output enables",
        int'({misoOe, sioOe}), int'({em, es}));
    if (em || es) begin
      got = em ? misoOut : sioOut;
      chk(got == expBit, req, "data out bit", int'(got), int'(expBit));
    end
  endtask

  // nBits of a frame with select already low; optional tx write after bit wrAt
  task automatic frameBits(input logic [7:0] mTx, input logic [7:0] sTx,
                           input int nBits, input int wrAt, input logic [7:0] wrVal);
    for (int i = 0; i < nBits; i++) begin
      if (!cfgCpha) begin
        setDin(bitOf(mTx, cfgLsbFirst, i));
        cyc(HALF);
        checkOut(bitOf(sTx, cfgLsbFirst, i), i == 0 ? "R3" : "R4");
        if (i == wrAt) writeTx(wrVal);
        sckIn = ~cfgCpol;
        cyc(HALF);
        sckIn = cfgCpol;
      end else begin
        sckIn = ~cfgCpol;
        setDin(bitOf(mTx, cfgLsbFirst, i));
        cyc(HALF);
        checkOut(bitOf(sTx, cfgLsbFirst, i), i == 0 ? "R3" : "R4");
        if (i == wrAt) writeTx(wrVal);
        sckIn = cfgCpol;
        cyc(HALF);
      end
    end
  endtask

  task automatic selectLow();
    ssNIn = 1'b0;
    cyc(HALF);
  endtask

  task automatic selectHigh();
    cyc(HALF);
    ssNIn = 1'b1;
    cyc(6);
  endtask

  task automatic fullFrame(input logic [7:0] mTx, input logic [7:0] sTx,
                           input bit doRead, input string req);
    writeTx(sTx);
    selectLow();
    frameBits(mTx, sTx, 8, -1, 8'h00);
    selectHigh();
    chk(!misoOe && !sioOe, "R2", "released after frame",
        int'({misoOe, sioOe}), 0);
    chk(rxByte == mTx, req, "received byte", int'(rxByte), int'(mTx));
    chk(rxFull == 1'b1, "R6", "full flag", int'(rxFull), 1);
    if (doRead) begin
      readRx();
      chk(rxFull == 1'b0, "R7", "flag after read", int'(rxFull), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h1F3A_55C7));
    cyc(4);
    rstN = 1'b1;
    cyc(2);
    // R1 reset state
    chk(rxByte == 8'h00, "R1", "rxByte at reset", int'(rxByte), 0);
    chk(rxFull == 1'b0, "R1", "rxFull at reset", int'(rxFull), 0);
    chk(!misoOe && !sioOe, "R1", "enables at reset", int'({misoOe, sioOe}), 0);

    // R4 R5 all clock formats, both orders
    for (int m = 0; m < 8; m++) begin
      setCfg(m[0], m[1], m[2], 2'd0, 1'b0);
      fullFrame(8'h3C ^ 8'(m * 17), 8'hA5 ^ 8'(m * 29), 1'b1, m[2] ? "R5" : "R4");
    end

    // R2 edges while deselected are ignored
    setCfg(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    writeTx(8'hF0);
    for (int k = 0; k < 20; k++) begin
      sckIn = ~sckIn;
      cyc(HALF);
      chk(!misoOe && !sioOe, "R2", "enable while deselected",
          int'({misoOe, sioOe}), 0);
    end
    sckIn = cfgCpol;
    cyc(6);
    chk(rxFull == 1'b0, "R2", "no frame from stray edges", int'(rxFull), 0);
    fullFrame(8'h96, 8'h5A, 1'b1, "R2");

    // R8 abort after three bits, buffer and flag untouched
    held = rxByte;
    writeTx(8'hC3);
    selectLow();
    frameBits(8'h0F, 8'hC3, 3, -1, 8'h00);
    selectHigh();
    chk(rxFull == 1'b0, "R8", "flag after abort", int'(rxFull), 0);
    chk(rxByte == held, "R8", "buffer after abort", int'(rxByte), int'(held));
    fullFrame(8'h71, 8'h2E, 1'b1, "R8");

    // R7 overwrite while full
    fullFrame(8'h11, 8'h22, 1'b0, "R6");
    fullFrame(8'hE7, 8'h44, 1'b0, "R7");
    chk(rxByte == 8'hE7, "R7", "overwritten buffer", int'(rxByte), 8'hE7);
    readRx();

    // R6 R10 back-to-back frames with mid-frame tx write, both phases
    for (int p = 0; p < 2; p++) begin
      setCfg(p[0], p[0], ~p[0], 2'd0, 1'b0);
      writeTx(8'h81);
      selectLow();
      frameBits(8'h5C, 8'h81, 8, 4, 8'h7E);
      cyc(HALF);
      chk(rxFull == 1'b1, "R6", "flag between frames", int'(rxFull), 1);
      chk(rxByte == 8'h5C, "R6", "first of two frames", int'(rxByte), 8'h5C);
      readRx();
      frameBits(8'hB3, 8'h7E, 8, -1, 8'h00);
      selectHigh();
      chk(rxByte == 8'hB3, "R10", "second of two frames", int'(rxByte), 8'hB3);
      readRx();
    end

    // R9 pin modes
    setCfg(1'b0, 1'b1, 1'b0, 2'd1, 1'b1);
    fullFrame(8'h6D, 8'h9B, 1'b1, "R9");
    setCfg(1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
    fullFrame(8'h24, 8'hFF, 1'b1, "R9");
    setCfg(1'b0, 1'b0, 1'b0, 2'd2, 1'b1);
    fullFrame(8'hD8, 8'h13, 1'b1, "R9");
    setCfg(1'b1, 1'b1, 1'b0, 2'd3, 1'b0);
    fullFrame(8'h4B, 8'hB4, 1'b1, "R9");

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [1:0] pm;
      pm = 2'($urandom % 4);
      setCfg(1'($urandom), 1'($urandom), 1'($urandom), pm, 1'($urandom));
      fullFrame(8'($urandom), 8'($urandom), 1'b1, "R6");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule